// File: doc/BRIEF.md
# Configurable Processing Cell for a Striped Reconfigurable Array

This block is one processing element of a row-organised coarse-grained array. Each cell computes once per clock from two operands and holds its result in an output register. That register then feeds the cells in the rows below it. Each operand has its own selector, and the selector chooses where that operand comes from. In the default vertical variant the choice is between the cell one row up, the cells two and three rows up in the same column, and one field of a wide side bus that belongs to the row. So a value produced several rows earlier, or a primary input, reaches the cell without a chain of cells spent only on relaying it.

A second variant replaces the wide selector with a two-way choice between the row-above input and a constant held in a register inside the cell. A first-row option removes the vertical selection altogether. Its operands then come straight from the top-of-array inputs, which are the `up1_i` port for the left operand and the `up2_i` port for the right. A small address-decoded port writes a control word and, in the constant variant, the two constants. This is done before execution starts. The control word sets the operation, the two source selects and the two side-bus field indices.

The cell adds exactly one register stage. Any alignment of values reaching back two or three rows is the job of the mapping.

Top module: `cgra_cell`

## Requirements
- R1: While reset is asserted and after it is released, `res_o` is zero and the control word is zero, which is the idle operation.
- R2: The operation code sits in control bits [2:0]. Codes 0 and 7 are idle: `res_o` keeps its value whatever the operands are.
- R3: Code 1 is pass: `res_o` becomes the left operand, unchanged.
- R4: Code 2 gives the sum of the two operands modulo 2^DW. Code 3 gives the low DW bits of their product.
- R5: Code 4 gives the bitwise AND of the two operands, and code 5 gives their bitwise OR.
- R6: Code 6 shifts the left operand right logically, filling with zeros, by the value in the low log2(DW) bits of the right operand.
- R7: In the vertical variant, the left select is in control bits [4:3] and the right select is in bits [6:5]. Select value 0 picks `up1_i`, 1 picks `up2_i`, 2 picks `up3_i` and 3 picks the side bus. The two operands are chosen independently.
- R8: The side-bus field index is clog2(SIDE_N) bits wide. With the default SIDE_N of 3 it sits in bits [8:7] for the left operand and in bits [10:9] for the right. Index i picks bits [i*DW +: DW] of that operand's own side bus, and an index of SIDE_N or more gives zero.
- R9: In the constant variant, bit 0 of an operand's select field chooses the source. A 1 picks that operand's local constant, written at address 1 for the left and address 2 for the right. A 0 picks `up1_i` for the left operand and `up2_i` for the right.
- R10: A write to address 0 loads the control word. The new word governs the result registered on the following clock edge, not on the edge of the write. A write to address 3 changes nothing, and so does a write to address 1 or 2 in a variant without constants.
- R11: With the first-row option, the select and field-index bits are ignored. The left operand is `up1_i` and the right operand is `up2_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address: 0 control, 1 left constant, 2 right constant |
| cfg_wdata | input | DW | Configuration write data |
| up1_i | input | DW | Result of the cell one row up, or the left top input |
| up2_i | input | DW | Result two rows up, or the right top input or right row-above input |
| up3_i | input | DW | Result three rows up in the same column |
| side_l_i | input | SIDE_N*DW | Row side bus for left operands, field 0 in the low bits |
| side_r_i | input | SIDE_N*DW | Row side bus for right operands, field 0 in the low bits |
| res_o | output | DW | Registered result |

## Verification
Every result appears on the first rising edge after its operands are presented. The bench changes inputs on a falling edge and samples `res_o` on the next falling edge, which is one register after the stimulus. A control-word write takes one edge to land and a second edge to show its effect. So right after a write the bench expects the result computed under the previous operation, and it expects the new operation's result one cycle later. The bench keeps a running model of the held value, so that idle cycles are checked against the last value it computed itself.

// File: rtl/cgra_cell_pkg.sv
package cgra_cell_pkg;

   typedef enum logic [2:0] {
      OP_IDLE = 3'd0,
      OP_PASS = 3'd1,
      OP_ADD  = 3'd2,
      OP_MUL  = 3'd3,
      OP_AND  = 3'd4,
      OP_OR   = 3'd5,
      OP_SRL  = 3'd6,
      OP_HOLD = 3'd7
   } op_e;

   localparam int VAR_VERT  = 0;
   localparam int VAR_CONST = 1;

   localparam int OP_W  = 3;
   localparam int SEL_W = 2;

endpackage

// File: rtl/cgra_cfg_regs.sv
module cgra_cfg_regs #(
   parameter int DW        = 16,
   parameter int CTRL_W    = 11,
   parameter int HAS_CONST = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DW-1:0]     cfg_wdata,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [DW-1:0]     const_l_o,
   output logic [DW-1:0]     const_r_o
);

   logic unused_cfg;
   assign unused_cfg = ^cfg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_o <= '0;
      end else if (cfg_we && cfg_addr == 2'd0) begin
         ctrl_o <= cfg_wdata[CTRL_W-1:0];
      end
   end

   generate
      if (HAS_CONST != 0) begin : g_const
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               const_l_o <= '0;
               const_r_o <= '0;
            end else if (cfg_we) begin
               if (cfg_addr == 2'd1) const_l_o <= cfg_wdata;
               if (cfg_addr == 2'd2) const_r_o <= cfg_wdata;
            end
         end
      end else begin : g_noconst
         assign const_l_o = '0;
         assign const_r_o = '0;
      end
   endgenerate

   // R10: writes to any address other than 0 leave the control word alone
   p_ctrl_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr != 2'd0) |=> $stable(ctrl_o));

endmodule

// File: rtl/cgra_opnd_sel.sv
module cgra_opnd_sel import cgra_cell_pkg::*; #(
   parameter int DW        = 16,
   parameter int SIDE_N    = 3,
   parameter int SLOT_W    = 2,
   parameter int VARIANT   = VAR_VERT,
   parameter int FIRST_ROW = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SEL_W-1:0]     sel,
   input  logic [SLOT_W-1:0]    slot,
   input  logic [DW-1:0]        up,
   input  logic [DW-1:0]        far2,
   input  logic [DW-1:0]        far3,
   input  logic [DW-1:0]        first,
   input  logic [SIDE_N*DW-1:0] side,
   input  logic [DW-1:0]        cst,
   output logic [DW-1:0]        opnd
);

   logic [DW-1:0] side_val;
   logic          unused_sel;

   assign unused_sel = ^{up, far2, far3, first, side, cst, sel, slot, clk, rst_n};

   always_comb begin
      side_val = '0;
      for (int i = 0; i < SIDE_N; i++) begin
         if (int'(slot) == i) side_val = side[i*DW +: DW];
      end
   end

   generate
      if (VARIANT == VAR_CONST) begin : g_const
         assign opnd = sel[0] ? cst : first;
      end else if (FIRST_ROW != 0) begin : g_top
         assign opnd = first;
      end else begin : g_vert
         always_comb begin
            case (sel)
               2'd0:    opnd = up;
               2'd1:    opnd = far2;
               2'd2:    opnd = far3;
               default: opnd = side_val;
            endcase
         end

         // R8: a field index past the packed inputs yields zero
         p_slot_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sel == 2'd3 && int'(slot) >= SIDE_N) |-> opnd == '0);
      end
   endgenerate

endmodule

// File: rtl/cgra_alu.sv
module cgra_alu import cgra_cell_pkg::*; #(
   parameter int DW = 16
) (
   input  op_e           op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y,
   output logic          hold
);

   localparam int SH_W = $clog2(DW);

   always_comb begin
      hold = 1'b0;
      y    = '0;
      case (op)
         OP_PASS: y = a;
         OP_ADD:  y = a + b;
         OP_MUL:  y = a * b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_SRL:  y = a >> b[SH_W-1:0];
         default: hold = 1'b1;
      endcase
   end

endmodule

// File: rtl/cgra_cell.sv
module cgra_cell import cgra_cell_pkg::*; #(
   parameter int DW        = 16,
   parameter int SIDE_N    = 3,
   parameter int VARIANT   = VAR_VERT,
   parameter int FIRST_ROW = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [1:0]           cfg_addr,
   input  logic [DW-1:0]        cfg_wdata,
   input  logic [DW-1:0]        up1_i,
   input  logic [DW-1:0]        up2_i,
   input  logic [DW-1:0]        up3_i,
   input  logic [SIDE_N*DW-1:0] side_l_i,
   input  logic [SIDE_N*DW-1:0] side_r_i,
   output logic [DW-1:0]        res_o
);

   localparam int SLOT_W    = (SIDE_N > 1) ? $clog2(SIDE_N) : 1;
   localparam int SELL_LSB  = OP_W;
   localparam int SELR_LSB  = SELL_LSB + SEL_W;
   localparam int SLOTL_LSB = SELR_LSB + SEL_W;
   localparam int SLOTR_LSB = SLOTL_LSB + SLOT_W;
   localparam int CTRL_W    = SLOTR_LSB + SLOT_W;

   generate
      if (DW < CTRL_W || DW < 4) begin : g_bad_width
         $error("cgra_cell: DW too small for the control word");
      end
      if (SIDE_N < 2) begin : g_bad_side
         $error("cgra_cell: SIDE_N must be at least 2");
      end
      if (VARIANT != VAR_VERT && VARIANT != VAR_CONST) begin : g_bad_var
         $error("cgra_cell: unknown VARIANT");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl;
   logic [DW-1:0]     const_l, const_r;
   logic [DW-1:0]     opnd_l, opnd_r, alu_y;
   logic              alu_hold;
   op_e               op;

   assign op = op_e'(ctrl[OP_W-1:0]);

   cgra_cfg_regs #(
      .DW(DW), .CTRL_W(CTRL_W), .HAS_CONST(VARIANT == VAR_CONST ? 1 : 0)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .ctrl_o(ctrl), .const_l_o(const_l),
      .const_r_o(const_r)
   );

   cgra_opnd_sel #(
      .DW(DW), .SIDE_N(SIDE_N), .SLOT_W(SLOT_W), .VARIANT(VARIANT),
      .FIRST_ROW(FIRST_ROW)
   ) u_sel_l (
      .clk(clk), .rst_n(rst_n),
      .sel(ctrl[SELL_LSB +: SEL_W]), .slot(ctrl[SLOTL_LSB +: SLOT_W]),
      .up(up1_i), .far2(up2_i), .far3(up3_i), .first(up1_i),
      .side(side_l_i), .cst(const_l), .opnd(opnd_l)
   );

   cgra_opnd_sel #(
      .DW(DW), .SIDE_N(SIDE_N), .SLOT_W(SLOT_W), .VARIANT(VARIANT),
      .FIRST_ROW(FIRST_ROW)
   ) u_sel_r (
      .clk(clk), .rst_n(rst_n),
      .sel(ctrl[SELR_LSB +: SEL_W]), .slot(ctrl[SLOTR_LSB +: SLOT_W]),
      .up(up1_i), .far2(up2_i), .far3(up3_i), .first(up2_i),
      .side(side_r_i), .cst(const_r), .opnd(opnd_r)
   );

   cgra_alu #(.DW(DW)) u_alu (
      .op(op), .a(opnd_l), .b(opnd_r), .y(alu_y), .hold(alu_hold)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o <= '0;
      end else if (!alu_hold) begin
         res_o <= alu_y;
      end
   end

   // R2: idle codes freeze the output register
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_IDLE || op == OP_HOLD) |=> $stable(res_o));

   // R3: pass forwards the selected left operand one edge later
   p_pass_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_PASS) |=> res_o == $past(opnd_l));

   // R5: an AND result never sets a bit absent from the left operand
   p_and_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_AND) |=> (res_o & ~$past(opnd_l)) == '0);

   // R6: a logical right shift never grows the value
   p_srl_shrink_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SRL) |=> res_o <= $past(opnd_l));

endmodule

// File: tb/cgra_cell_tb_top.sv
`timescale 1ns/1ps
module cgra_cell_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [15:0] cfg_wdata = 16'd0;
   logic [15:0] up1 = 16'd0, up2 = 16'd0, up3 = 16'd0;
   logic [47:0] side_l = 48'd0, side_r = 48'd0;
   logic [15:0] res_i, res_c, res_f;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   localparam logic [15:0] CL = 16'h0070;
   localparam logic [15:0] CR = 16'h0700;

   always #2.5 clk = ~clk;

   cgra_cell dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .up1_i(up1), .up2_i(up2), .up3_i(up3),
      .side_l_i(side_l), .side_r_i(side_r), .res_o(res_i)
   );

   cgra_cell #(.VARIANT(cgra_cell_pkg::VAR_CONST)) dut_c (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .up1_i(up1), .up2_i(up2), .up3_i(up3),
      .side_l_i(side_l), .side_r_i(side_r), .res_o(res_c)
   );

   cgra_cell #(.FIRST_ROW(1)) dut_f (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .up1_i(up1), .up2_i(up2), .up3_i(up3),
      .side_l_i(side_l), .side_r_i(side_r), .res_o(res_f)
   );

   function automatic logic [15:0] f_alu(input int op, input logic [15:0] a,
                                         input logic [15:0] b, input logic [15:0] prev);
      case (op)
         1: return a;
         2: return a + b;
         3: return a * b;
         4: return a & b;
         5: return a | b;
         6: return a >> b[3:0];
         default: return prev;
      endcase
   endfunction

   function automatic logic [15:0] mk_ctrl(input int op, input int sl, input int sr,
                                           input int tl, input int tr);
      logic [15:0] c;
      c = 16'd0;
      c[2:0]  = op[2:0];
      c[4:3]  = sl[1:0];
      c[6:5]  = sr[1:0];
      c[8:7]  = tl[1:0];
      c[10:9] = tr[1:0];
      return c;
   endfunction

   function automatic logic [15:0] vsrc(input int sel, input int slot, input bit right);
      case (sel)
         0: return up1;
         1: return up2;
         2: return up3;
         default: begin
            if (slot >= 3) return 16'd0;
            return right ? side_r[slot*16 +: 16] : side_l[slot*16 +: 16];
         end
      endcase
   endfunction

   function automatic string op_tag(input int op);
      case (op)
         1: return "R3";
         2, 3: return "R4";
         4, 5: return "R5";
         6: return "R6";
         default: return "R2";
      endcase
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cfg_wr(input logic [1:0] a, input logic [15:0] d);
      cfg_we = 1'b1;
      cfg_addr = a;
      cfg_wdata = d;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [15:0] expv;
      int          cur_op;

      side_l = {16'h4000, 16'h2000, 16'h1000};
      side_r = {16'h0300, 16'h0030, 16'h0003};
      @(negedge clk);
      repeat (3) step();
      chk("R1 reset vert", res_i, 16'd0);
      chk("R1 reset const", res_c, 16'd0);
      chk("R1 reset first", res_f, 16'd0);
      rst_n = 1'b1;
      up1 = 16'h1234;
      up2 = 16'h5678;
      step();
      chk("R1 idle after reset", res_i, 16'd0);
      chk("R2 idle after reset", res_c, 16'd0);

      // operation sweep: left from up1, right from up2
      expv = 16'd0;
      cur_op = 0;
      for (int op = 0; op < 8; op++) begin
         expv = f_alu(cur_op, up1, up2, expv);
         cfg_wr(2'd0, mk_ctrl(op, 0, 1, 0, 0));
         cur_op = op;
         chk("R10 write edge uses old op", res_i, expv);
         for (int k = 0; k < 6; k++) begin
            up1 = 16'hA5C3 ^ 16'(k * 16'h1357);
            case (k)
               0: up2 = 16'h0000;
               1: up2 = 16'hFFFF;
               2: up2 = 16'd19;
               3: up2 = 16'd15;
               default: up2 = 16'(k * 16'h3C5A);
            endcase
            step();
            expv = f_alu(op, up1, up2, expv);
            chk(op_tag(op), res_i, expv);
         end
      end

      // configuration timing and ignored address
      cfg_wr(2'd0, mk_ctrl(2, 0, 1, 0, 0));
      up1 = 16'h0F0F;
      up2 = 16'h0101;
      step();
      chk("R4 add", res_i, 16'h1010);
      cfg_wr(2'd0, mk_ctrl(1, 0, 1, 0, 0));
      chk("R10 old op on write edge", res_i, 16'h1010);
      step();
      chk("R10 new op next edge", res_i, 16'h0F0F);
      up1 = 16'h0abc;
      cfg_wr(2'd3, mk_ctrl(2, 0, 1, 0, 0));
      chk("R10 addr3 write edge", res_i, 16'h0abc);
      step();
      chk("R10 addr3 ignored", res_i, 16'h0abc);
      cfg_wr(2'd1, mk_ctrl(2, 0, 1, 0, 0));
      step();
      chk("R10 addr1 ignored vert", res_i, 16'h0abc);

      // selector sweep
      cfg_wr(2'd1, CL);
      cfg_wr(2'd2, CR);
      up1 = 16'h0001;
      up2 = 16'h0010;
      up3 = 16'h0100;
      for (int sl = 0; sl < 4; sl++) begin
         for (int sr = 0; sr < 4; sr++) begin
            for (int tl = 0; tl < 4; tl++) begin
               for (int tr = 0; tr < 4; tr++) begin
                  cfg_wr(2'd0, mk_ctrl(2, sl, sr, tl, tr));
                  step();
                  chk((sl == 3 || sr == 3) ? "R8 side field" : "R7 vertical select",
                      res_i, vsrc(sl, tl, 1'b0) + vsrc(sr, tr, 1'b1));
                  chk("R9 const select", res_c,
                      (sl[0] ? CL : up1) + (sr[0] ? CR : up2));
                  chk("R11 first row", res_f, up1 + up2);
               end
            end
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule